// File: doc/BRIEF.md
# Synchronous Burst SRAM Command Decoder

This block sits between a host and a flow-through synchronous SRAM array. On every rising clock edge it samples three chip enables, two address strobes (one meant for a processor, one for a cache controller), a burst advance input and the write controls. From these it classifies the cycle. It then drives registered commands toward the array and the burst address counter: an array read strobe, per-lane write enables, an address load pulse and an address step pulse.

The block records whether the burst in progress is a read or a write, so continue and suspend cycles keep that direction. The drive enable for the data bus combines the registered read indication with an asynchronous, active-low output enable. That enable can turn the drivers off at any moment. It can turn them on only during read cycles.

Top module: `sbsram_cmd_decoder`

## Requirements
- R1: While reset is high, and on the first edge after reset, `cyc_code` is 0 and `arr_rd`, `arr_we`, `addr_load`, `addr_step` and `bus_drive` are all 0.
- R2: When `en_main_n`=1 and `strb_ctl_n`=0 at an edge, the cycle is a no-operation (`cyc_code`=0, no array access), whatever `strb_host_n` is. Any burst in progress ends.
- R3: When `en_main_n`=0, either strobe is low, and the chip is not fully enabled (`en_hi`=0 or `en_aux_n`=1), the cycle is a no-operation (`cyc_code`=0) and any burst ends.
- R4: When the chip is fully enabled (`en_main_n`=0, `en_hi`=1, `en_aux_n`=0) and `strb_host_n`=0, a read burst begins: `cyc_code`=1, `arr_rd`=1, `addr_load`=1. The write inputs are ignored.
- R5: When the chip is fully enabled, `strb_host_n`=1 and `strb_ctl_n`=0, a burst begins with `addr_load`=1. It is a read (`cyc_code`=1) or a write (`cyc_code`=2) according to the write decode of R6.
- R6: Write decode: `wr_all_n`=0 selects every lane. Otherwise `wr_byte_n`=0 selects the lanes whose `lane_n` bit is 0, with bit i controlling lane i. No lane selected means a read. During a write cycle, `arr_we` bit i is 1 exactly for the selected lanes, and `arr_rd`=0.
- R7: When both strobes are high during an active burst, `burst_next_n`=0 gives a continue cycle with `addr_step`=1 (code 3 for a read burst, 4 for a write burst). `burst_next_n`=1 gives a suspend cycle with no step (code 5 for read, 6 for write). `en_main_n` is ignored in both cases. `strb_host_n` is ignored while `en_main_n`=1. Continue and suspend write cycles take lanes from the current write decode.
- R8: A continue or suspend request with no burst active (after reset or after a no-operation cycle) yields `cyc_code`=0 with no access.
- R9: In every write cycle `bus_drive`=0. In a read cycle, whatever the lane selects are, `bus_drive` equals the inverse of `out_en_n`.
- R10: `out_en_n` acts without a clock. Raising it drops `bus_drive` at once. Lowering it during a read cycle raises `bus_drive` at once.
- R11: A read continue with `out_en_n`=1 (a dummy read) still gives `addr_step`=1 and `cyc_code`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en_main_n | input | 1 | Primary chip enable, active low |
| en_hi | input | 1 | Secondary chip enable, active high |
| en_aux_n | input | 1 | Secondary chip enable, active low |
| strb_host_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| burst_next_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Per-lane write qualifier, active low |
| lane_n | input | LANES | Per-lane selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| cyc_code | output | 3 | Registered cycle class (0 nop, 1 begin rd, 2 begin wr, 3 cont rd, 4 cont wr, 5 susp rd, 6 susp wr) |
| arr_rd | output | 1 | Array read for the current cycle |
| arr_we | output | LANES | Per-lane array write enables |
| addr_load | output | 1 | Load the external address into the burst counter |
| addr_step | output | 1 | Step the burst counter |
| bus_drive | output | 1 | Data bus driver enable |
| burst_wr | output | 1 | Direction of the current burst (1 = write) |

## Verification
The stimulus covers both strobes with the chip fully enabled and with it partly enabled. This separates a processor-started read from a controller-started access, and separates those from the two ways a cycle can become a no-operation. The write decode is tried with global write, sparse and full lane masks, byte-write without any lane, and no write request at all; this separates lane writes from reads. Continue and suspend cycles are run after read and write starts, with the primary enable and the processor strobe toggled, and after a no-operation. These show that direction is remembered and that ignored inputs have no effect. A dummy read and a mid-cycle output-enable toggle separate address stepping from bus driving.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [2:0] {
    CY_NOP    = 3'd0,
    CY_BEG_RD = 3'd1,
    CY_BEG_WR = 3'd2,
    CY_CON_RD = 3'd3,
    CY_CON_WR = 3'd4,
    CY_SUS_RD = 3'd5,
    CY_SUS_WR = 3'd6
  } cyc_e;
endpackage

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lane_mask,
  output logic             is_write
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g] = !wr_all_n || (!wr_byte_n && !lane_n[g]);
  end
  assign is_write = |lane_mask;
endmodule

// File: rtl/sbsram_cycle_class.sv
module sbsram_cycle_class
  import sbsram_pkg::*;
(
  input  logic en_main_n,
  input  logic en_hi,
  input  logic en_aux_n,
  input  logic strb_host_n,
  input  logic strb_ctl_n,
  input  logic burst_next_n,
  input  logic is_write,
  input  logic burst_act,
  input  logic burst_wr,
  output cyc_e nxt
);
  logic full_en;
  assign full_en = !en_main_n && en_hi && !en_aux_n;

  always_comb begin
    nxt = CY_NOP;
    if (en_main_n && !strb_ctl_n) begin
      nxt = CY_NOP;
    end else if (!en_main_n && (!strb_host_n || !strb_ctl_n)) begin
      if (!full_en)          nxt = CY_NOP;
      else if (!strb_host_n) nxt = CY_BEG_RD;
      else if (is_write)     nxt = CY_BEG_WR;
      else                   nxt = CY_BEG_RD;
    end else if (burst_act) begin
      if (!burst_next_n) nxt = burst_wr ? CY_CON_WR : CY_CON_RD;
      else               nxt = burst_wr ? CY_SUS_WR : CY_SUS_RD;
    end
  end
endmodule

// File: rtl/sbsram_burst_state.sv
module sbsram_burst_state
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cyc_e             nxt,
  input  logic [LANES-1:0] lane_mask,
  output cyc_e             cyc_q,
  output logic             rd_q,
  output logic [LANES-1:0] we_q,
  output logic             load_q,
  output logic             step_q,
  output logic             act_q,
  output logic             wr_q
);
  logic nxt_wr_type;
  logic nxt_rd_type;
  assign nxt_wr_type = (nxt == CY_BEG_WR) || (nxt == CY_CON_WR) || (nxt == CY_SUS_WR);
  assign nxt_rd_type = (nxt == CY_BEG_RD) || (nxt == CY_CON_RD) || (nxt == CY_SUS_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= CY_NOP;
      rd_q   <= 1'b0;
      we_q   <= '0;
      load_q <= 1'b0;
      step_q <= 1'b0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      cyc_q  <= nxt;
      rd_q   <= nxt_rd_type;
      we_q   <= nxt_wr_type ? lane_mask : '0;
      load_q <= (nxt == CY_BEG_RD) || (nxt == CY_BEG_WR);
      step_q <= (nxt == CY_CON_RD) || (nxt == CY_CON_WR);
      act_q  <= (nxt != CY_NOP);
      if (nxt == CY_BEG_WR)      wr_q <= 1'b1;
      else if (nxt == CY_BEG_RD) wr_q <= 1'b0;
    end
  end

  // R7: a continue or suspend keeps the direction the burst began with
  assert_dir_kept_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(act_q) && !load_q && act_q) |-> (wr_q == $past(wr_q)));

  // R6: read and write never share a cycle
  assert_rd_we_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && (|we_q)));

  // R7: load and step are exclusive
  assert_load_step_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(load_q && step_q));
endmodule

// File: rtl/sbsram_cmd_decoder.sv
module sbsram_cmd_decoder
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_main_n,
  input  logic             en_hi,
  input  logic             en_aux_n,
  input  logic             strb_host_n,
  input  logic             strb_ctl_n,
  input  logic             burst_next_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             out_en_n,
  output logic [2:0]       cyc_code,
  output logic             arr_rd,
  output logic [LANES-1:0] arr_we,
  output logic             addr_load,
  output logic             addr_step,
  output logic             bus_drive,
  output logic             burst_wr
);
  logic [LANES-1:0] lane_mask;
  logic             is_write;
  cyc_e             nxt;
  cyc_e             cyc_q;
  logic             act_q;

  sbsram_wr_decode #(.LANES(LANES)) u_wdec (
    .wr_all_n (wr_all_n),
    .wr_byte_n(wr_byte_n),
    .lane_n   (lane_n),
    .lane_mask(lane_mask),
    .is_write (is_write)
  );

  sbsram_cycle_class u_cls (
    .en_main_n   (en_main_n),
    .en_hi       (en_hi),
    .en_aux_n    (en_aux_n),
    .strb_host_n (strb_host_n),
    .strb_ctl_n  (strb_ctl_n),
    .burst_next_n(burst_next_n),
    .is_write    (is_write),
    .burst_act   (act_q),
    .burst_wr    (burst_wr),
    .nxt         (nxt)
  );

  sbsram_burst_state #(.LANES(LANES)) u_st (
    .clk      (clk),
    .rst      (rst),
    .nxt      (nxt),
    .lane_mask(lane_mask),
    .cyc_q    (cyc_q),
    .rd_q     (arr_rd),
    .we_q     (arr_we),
    .load_q   (addr_load),
    .step_q   (addr_step),
    .act_q    (act_q),
    .wr_q     (burst_wr)
  );

  assign cyc_code  = cyc_q;
  assign bus_drive = arr_rd && !out_en_n;

  // R9: bus never driven while any lane is written
  always_comb begin
    if (!rst && (|arr_we)) assert_no_drive_on_write_R9: assert (!bus_drive);
  end

  // R2: first enable high with controller strobe low is a no-operation
  assert_desel_ctl_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(en_main_n) && !$past(strb_ctl_n)) |-> (cyc_code == 3'd0 && !arr_rd && arr_we == '0));

  // R4: processor strobe with full enable always begins a read
  assert_host_read_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!en_main_n && en_hi && !en_aux_n && !strb_host_n)) |-> (cyc_code == 3'd1 && addr_load));

  // R1: first edge after reset is idle
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cyc_code == 3'd0 && !arr_rd && arr_we == '0 && !addr_load && !addr_step));
endmodule

// File: tb/test_sbsram_cmd_decoder.sv
`timescale 1ns/100ps
module test_sbsram_cmd_decoder;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_main_n = 1'b1, en_hi = 1'b0, en_aux_n = 1'b1;
  logic strb_host_n = 1'b1, strb_ctl_n = 1'b1, burst_next_n = 1'b1;
  logic wr_all_n = 1'b1, wr_byte_n = 1'b1, out_en_n = 1'b0;
  logic [L-1:0] lane_n = '1;
  logic [2:0] cyc_code;
  logic arr_rd, addr_load, addr_step, bus_drive, burst_wr;
  logic [L-1:0] arr_we;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  sbsram_cmd_decoder #(.LANES(L)) i_sbsram_cmd_decoder (
    .clk(clk), .rst(rst), .en_main_n(en_main_n), .en_hi(en_hi), .en_aux_n(en_aux_n),
    .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n), .burst_next_n(burst_next_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n), .out_en_n(out_en_n),
    .cyc_code(cyc_code), .arr_rd(arr_rd), .arr_we(arr_we), .addr_load(addr_load),
    .addr_step(addr_step), .bus_drive(bus_drive), .burst_wr(burst_wr)
  );

  typedef struct {
    logic [2:0]   code;
    logic         rd;
    logic [L-1:0] we;
    logic         ld;
    logic         st;
    logic         drv;
    string        req;
  } exp_t;

  exp_t exp_q[$];
  logic m_act = 1'b0;
  logic m_wr  = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // driver: apply one cycle and push the expected registered result
  task automatic cyc(input logic e1n, input logic e2, input logic e3n, input logic psn,
                     input logic csn, input logic advn, input logic gwn, input logic bwn,
                     input logic [L-1:0] ln, input logic oen, input string req);
    exp_t e;
    logic [L-1:0] mask;
    logic full;
    @(negedge clk);
    en_main_n = e1n; en_hi = e2; en_aux_n = e3n; strb_host_n = psn; strb_ctl_n = csn;
    burst_next_n = advn; wr_all_n = gwn; wr_byte_n = bwn; lane_n = ln; out_en_n = oen;
    mask = !gwn ? '1 : (!bwn ? ~ln : '0);
    full = !e1n && e2 && !e3n;
    e.code = 3'd0;
    if (e1n && !csn)                   e.code = 3'd0;
    else if (!e1n && (!psn || !csn)) begin
      if (!full)      e.code = 3'd0;
      else if (!psn)  e.code = 3'd1;
      else            e.code = (mask != '0) ? 3'd2 : 3'd1;
    end else if (m_act) begin
      if (!advn) e.code = m_wr ? 3'd4 : 3'd3;
      else       e.code = m_wr ? 3'd6 : 3'd5;
    end
    e.rd  = (e.code == 3'd1) || (e.code == 3'd3) || (e.code == 3'd5);
    e.we  = ((e.code == 3'd2) || (e.code == 3'd4) || (e.code == 3'd6)) ? mask : '0;
    e.ld  = (e.code == 3'd1) || (e.code == 3'd2);
    e.st  = (e.code == 3'd3) || (e.code == 3'd4);
    e.drv = e.rd && !oen;
    e.req = req;
    m_act = (e.code != 3'd0);
    if (e.code == 3'd2) m_wr = 1'b1;
    else if (e.code == 3'd1) m_wr = 1'b0;
    exp_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc_code == e.code, e.req, "cyc_code", cyc_code, e.code);
        check(arr_rd == e.rd, e.req, "arr_rd", arr_rd, e.rd);
        check(arr_we == e.we, e.req, "arr_we", arr_we, e.we);
        check(addr_load == e.ld, e.req, "addr_load", addr_load, e.ld);
        check(addr_step == e.st, e.req, "addr_step", addr_step, e.st);
        check(bus_drive == e.drv, e.req, "bus_drive", bus_drive, e.drv);
      end
    end
  end

  initial begin
    #(8 * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(cyc_code == 3'd0 && !arr_rd && arr_we == '0 && !addr_load && !addr_step && !bus_drive,
          "R1", "reset outputs", {cyc_code, arr_rd, arr_we}, 0);
    @(negedge clk);
    rst = 1'b0;
    // R1/R8: continue request with no burst right after reset
    cyc(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 0, "R1 R8 idle after reset");
    // R4: host strobe read even with global write low
    cyc(0, 1, 0, 0, 1, 1, 0, 0, 4'h0, 0, "R4 host begin read");
    cyc(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 0, "R7 continue read");
    // R7: first enable high and host strobe low are ignored
    cyc(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, 0, "R7 ignored enables");
    cyc(0, 1, 0, 1, 1, 1, 1, 1, 4'hF, 0, "R7 suspend read");
    // R2: deselect by controller strobe with first enable high
    cyc(1, 1, 0, 0, 0, 0, 0, 1, 4'hF, 0, "R2 deselect");
    cyc(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 0, "R8 continue after deselect");
    // R5/R6/R9: controller strobe write with sparse lanes (lane_n 1010 -> lanes 0,2)
    cyc(0, 1, 0, 1, 0, 1, 1, 0, 4'hA, 0, "R5 R6 R9 begin write lanes");
    cyc(1, 0, 1, 1, 1, 0, 0, 1, 4'hF, 0, "R7 continue write all");
    cyc(0, 1, 0, 1, 1, 1, 1, 0, 4'hD, 0, "R7 suspend write lane1");
    cyc(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 0, "R7 continue write no lanes");
    // R6: byte write with no lane selected is a read
    cyc(0, 1, 0, 1, 0, 1, 1, 0, 4'hF, 0, "R6 no lane read");
    // R9: plain read with lanes low still drives
    cyc(0, 1, 0, 1, 0, 1, 1, 1, 4'h0, 0, "R9 read drives");
    // R3: partly enabled
    cyc(0, 0, 0, 1, 0, 1, 0, 1, 4'hF, 0, "R3 en_hi low");
    cyc(0, 1, 1, 0, 1, 1, 1, 1, 4'hF, 0, "R3 en_aux high");
    cyc(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 0, "R3 R8 burst ended");
    // R5: full write by global write through controller strobe
    cyc(0, 1, 0, 1, 0, 1, 0, 1, 4'hF, 0, "R5 R6 global write");
    // R11: dummy read still steps
    cyc(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 1, "R11 begin read oe high");
    cyc(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 1, "R11 dummy continue");
    // R10: asynchronous output enable
    cyc(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0, "R10 begin read");
    @(posedge clk);
    #3;
    out_en_n = 1'b1;
    #0.5;
    check(bus_drive == 1'b0, "R10", "bus_drive after oe high", bus_drive, 0);
    out_en_n = 1'b0;
    #0.3;
    check(bus_drive == 1'b1, "R10", "bus_drive after oe low", bus_drive, 1);
    cyc(1, 0, 1, 1, 0, 1, 1, 1, 4'hF, 0, "R2 final deselect");
    repeat (3) @(posedge clk);
    #3;
    check(exp_q.size() == 0, "R1", "queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule